// File: doc/BRIEF.md
# Start-Synchronised Tempo Clock Generator

This block produces the tempo clock that paces a step sequencer. An internal oscillator counts down a programmable number of system clock cycles. Each time the count expires it flips a divide-by-two stage, so the tempo clock spends exactly one programmed period high and one low. The oscillator runs from reset onward, whether the pattern is playing or not. A downstream sequencer treats 24 tempo clock cycles as one quarter note.

A one-cycle, already debounced button pulse toggles the run state. Pressing it while stopped does not simply enable the clock. The oscillator freezes with the tempo clock held low for a fixed preparation window of `PREP_CYCLES` system cycles. At the end of that window the tempo clock rises and the run output goes active on the same edge, and the oscillator restarts from a full period. Pressing it while running stops the run state at once and leaves the oscillator alone.

A sync-select input hands both outputs to an external clock and an external run signal. While it is set, the internal oscillator and the run toggle are parked and the button is ignored.

Top module: `tempo_clk_gen`

## Requirements
- R1: While reset is high, `tclk_o` and `run_o` are 0. Reset is synchronous and active high. The first rising edge of `tclk_o` comes at the first clock edge after reset is released.
- R2: While internal mode is selected, `tclk_o` toggles every P system cycles, both when stopped and when running, where P is the value of `period_i`.
- R3: A new `period_i` value does not shorten or stretch the half period in progress. It is sampled when the counter reloads, so it sets the length of the next half period.
- R4: A press (`start_btn_i` high for one cycle) while stopped in internal mode forces `tclk_o` low and freezes the oscillator. Exactly `PREP_CYCLES` clock edges after the edge that sampled the press, `tclk_o` rises and `run_o` rises on the same edge.
- R5: After a restart, the first half period and the ones after it last P cycles.
- R6: A press while running clears `run_o` on the next clock edge and does not disturb the phase of `tclk_o`.
- R7: A press during the preparation window is ignored: the window ends at its normal time and `run_o` rises.
- R8: With `sync_ext_i` high, `tclk_o` and `run_o` equal `ext_clk_i` and `ext_run_i` delayed by one register stage. The mode select itself also takes effect one cycle after it is sampled.
- R9: In external mode the button has no effect. On return to internal mode, the block is stopped with `tclk_o` low, and `tclk_o` rises one cycle after the outputs switch back.
- R10: A `period_i` value of 0 or 1 is treated as 2, so the oscillator never produces expirations on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | PERIOD_W | Half period of the tempo clock in system cycles |
| start_btn_i | input | 1 | One-cycle start/stop press |
| ext_clk_i | input | 1 | External tempo clock, used in external mode |
| ext_run_i | input | 1 | External run level, used in external mode |
| sync_ext_i | input | 1 | 1 selects the external clock and run inputs |
| tclk_o | output | 1 | Tempo clock |
| run_o | output | 1 | Run state |

## Verification
Several half periods are timed with the pattern stopped. The period is then changed part way through a half period, which separates a reload-time sample from an immediate one. Start presses are timed from the sampling edge to the first rising edge, once clean and once with a second press inside the window; this shows whether the gap is fixed and whether a press inside it is ignored. A stop press while running checks that only the run state changes. An external-mode stretch drives mixed clock and run patterns, presses the button, and then returns to internal mode to check the parked state and the first internal edge. A behavioural model is compared against both outputs on every clock throughout.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

    // Controls from the run sequencer to the oscillator and divider
    typedef struct packed {
        logic freeze;   // preparation window active
        logic restart;  // last cycle of the window
        logic clear;    // press accepted while stopped
    } osc_ctl_t;

    localparam int unsigned MIN_HALF = 2;

    // Reload value for a down counter that expires every p cycles (p >= 2)
    function automatic logic [31:0] half_reload(input logic [31:0] p);
        if (p < MIN_HALF)
            return MIN_HALF - 1;
        return p - 32'd1;
    endfunction

endpackage

// File: rtl/tcg_osc.sv
module tcg_osc #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    input  logic                freeze,
    input  logic                restart,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                tick_o
);
    import tcg_pkg::*;

    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] reload_val;
    logic                at_zero;

    assign reload_val = PERIOD_W'(half_reload(32'(period_i)));
    assign at_zero    = (cnt_q == '0);
    assign tick_o     = at_zero && !hold && !freeze && !restart;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (hold)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= reload_val;
        else if (freeze)
            cnt_q <= cnt_q;
        else if (at_zero)
            cnt_q <= reload_val;
        else
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/tcg_runctl.sv
module tcg_runctl #(
    parameter int PREP_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              btn_i,
    output tcg_pkg::osc_ctl_t ctl_o,
    output logic              run_o
);
    import tcg_pkg::*;

    localparam int GW = (PREP_CYCLES > 1) ? $clog2(PREP_CYCLES) : 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(PREP_CYCLES - 1);

    run_state_e    state_q;
    logic [GW-1:0] gap_q;
    logic          gap_done;

    assign gap_done      = (state_q == ST_PREP) && (gap_q == '0);
    assign ctl_o.freeze  = (state_q == ST_PREP);
    assign ctl_o.restart = gap_done;
    assign ctl_o.clear   = (state_q == ST_STOP) && btn_i && !hold;
    assign run_o         = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_STOP;
            gap_q   <= '0;
        end else if (hold) begin
            state_q <= ST_STOP;
        end else begin
            unique case (state_q)
                ST_STOP: if (btn_i) begin
                    state_q <= ST_PREP;
                    gap_q   <= GAP_LAST;
                end
                ST_PREP: if (gap_done)
                    state_q <= ST_RUN;
                else
                    gap_q <= gap_q - 1'b1;
                ST_RUN: if (btn_i)
                    state_q <= ST_STOP;
                default: state_q <= ST_STOP;
            endcase
        end
    end
endmodule

// File: rtl/tcg_div.sv
module tcg_div (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set,
    input  logic tick,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q_o <= 1'b0;
        else if (set)
            q_o <= 1'b1;
        else if (tick)
            q_o <= !q_o;
    end
endmodule

// File: rtl/tcg_extsel.sv
module tcg_extsel (
    input  logic clk,
    input  logic rst,
    input  logic sync_ext_i,
    input  logic ext_clk_i,
    input  logic ext_run_i,
    input  logic int_clk,
    input  logic int_run,
    output logic mode_q,
    output logic tclk_o,
    output logic run_o
);
    logic eclk_q;
    logic erun_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            eclk_q <= 1'b0;
            erun_q <= 1'b0;
        end else begin
            mode_q <= sync_ext_i;
            eclk_q <= ext_clk_i;
            erun_q <= ext_run_i;
        end
    end

    assign tclk_o = mode_q ? eclk_q : int_clk;
    assign run_o  = mode_q ? erun_q : int_run;
endmodule

// File: rtl/tempo_clk_gen.sv
module tempo_clk_gen #(
    parameter int PERIOD_W    = 16,  // at most 32
    parameter int PREP_CYCLES = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                start_btn_i,
    input  logic                ext_clk_i,
    input  logic                ext_run_i,
    input  logic                sync_ext_i,
    output logic                tclk_o,
    output logic                run_o
);
    import tcg_pkg::*;

    osc_ctl_t ctl;
    logic     mode_q;
    logic     osc_tick;
    logic     tclk_int;
    logic     run_int;
    logic     gap_freeze;
    logic     gap_restart;

    assign gap_freeze  = ctl.freeze;
    assign gap_restart = ctl.restart;

    tcg_runctl #(.PREP_CYCLES(PREP_CYCLES)) u_runctl (
        .clk   (clk),
        .rst   (rst),
        .hold  (mode_q),
        .btn_i (start_btn_i),
        .ctl_o (ctl),
        .run_o (run_int)
    );

    tcg_osc #(.PERIOD_W(PERIOD_W)) u_osc (
        .clk      (clk),
        .rst      (rst),
        .hold     (mode_q),
        .freeze   (ctl.freeze),
        .restart  (ctl.restart),
        .period_i (period_i),
        .tick_o   (osc_tick)
    );

    tcg_div u_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (mode_q || ctl.clear),
        .set  (ctl.restart),
        .tick (osc_tick),
        .q_o  (tclk_int)
    );

    tcg_extsel u_extsel (
        .clk        (clk),
        .rst        (rst),
        .sync_ext_i (sync_ext_i),
        .ext_clk_i  (ext_clk_i),
        .ext_run_i  (ext_run_i),
        .int_clk    (tclk_int),
        .int_run    (run_int),
        .mode_q     (mode_q),
        .tclk_o     (tclk_o),
        .run_o      (run_o)
    );
endmodule

// File: rtl/tcg_chk.sv
module tcg_chk (
    input logic clk,
    input logic rst,
    input logic btn_i,
    input logic ext_clk_i,
    input logic mode_q,
    input logic tick,
    input logic freeze,
    input logic restart,
    input logic run_int,
    input logic tclk_int,
    input logic tclk_o
);
    AST_START_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(run_int) |-> $rose(tclk_int)); // R4

    AST_GAP_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
        freeze |-> !tclk_int); // R4

    AST_STOP_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
        (run_int && btn_i && !mode_q) |=> !run_int); // R6

    AST_GAP_IGNORES_PRESS: assert property (@(posedge clk) disable iff (rst)
        (freeze && !restart && btn_i && !mode_q) |=> freeze); // R7

    AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q && $past(mode_q)) |-> (tclk_o == $past(ext_clk_i))); // R8

    AST_EXT_PARKS: assert property (@(posedge clk) disable iff (rst)
        mode_q |=> !run_int); // R9

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R10
endmodule

bind tempo_clk_gen tcg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .btn_i     (start_btn_i),
    .ext_clk_i (ext_clk_i),
    .mode_q    (mode_q),
    .tick      (osc_tick),
    .freeze    (gap_freeze),
    .restart   (gap_restart),
    .run_int   (run_int),
    .tclk_int  (tclk_int),
    .tclk_o    (tclk_o)
);

// File: tb/tempo_clk_gen_tb.sv
module tempo_clk_gen_tb;
    localparam int PW   = 16;
    localparam int PREP = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] period_i = 16'd5;
    logic          btn = 1'b0;
    logic          ext_clk = 1'b0;
    logic          ext_run = 1'b0;
    logic          sync_ext = 1'b0;
    logic          tclk_o;
    logic          run_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = !clk;

    tempo_clk_gen #(.PERIOD_W(PW), .PREP_CYCLES(PREP)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .period_i    (period_i),
        .start_btn_i (btn),
        .ext_clk_i   (ext_clk),
        .ext_run_i   (ext_run),
        .sync_ext_i  (sync_ext),
        .tclk_o      (tclk_o),
        .run_o       (run_o)
    );

    // Behavioural reference: 0 stopped, 1 preparing, 2 running
    int m_cnt, m_gap, m_phase;
    bit m_tclk, m_mode, m_eclk, m_erun;

    function automatic int half_of(int p);
        return (p < 2) ? 2 : p;
    endfunction

    always @(posedge clk) begin
        bit expired;
        if (rst) begin
            m_cnt = 0; m_gap = 0; m_phase = 0;
            m_tclk = 0; m_mode = 0; m_eclk = 0; m_erun = 0;
        end else begin
            if (m_mode) begin
                m_phase = 0; m_cnt = 0; m_tclk = 0;
            end else if (m_phase == 1) begin
                if (m_gap == 0) begin
                    m_phase = 2; m_tclk = 1;
                    m_cnt = half_of(int'(period_i)) - 1;
                end else begin
                    m_gap = m_gap - 1;
                end
            end else begin
                expired = (m_cnt == 0);
                m_cnt = expired ? half_of(int'(period_i)) - 1 : m_cnt - 1;
                if (m_phase == 0 && btn) begin
                    m_phase = 1; m_gap = PREP - 1; m_tclk = 0;
                end else begin
                    if (expired) m_tclk = !m_tclk;
                    if (m_phase == 2 && btn) m_phase = 0;
                end
            end
            m_mode = sync_ext; m_eclk = ext_clk; m_erun = ext_run;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(tclk_o == (m_mode ? m_eclk : m_tclk), m_mode ? "R8 tclk vs model" : "R2 tclk vs model",
                int'(tclk_o), int'(m_mode ? m_eclk : m_tclk));
            chk(run_o == (m_mode ? m_erun : (m_phase == 2)), m_mode ? "R8 run vs model" : "R4 run vs model",
                int'(run_o), int'(m_mode ? m_erun : (m_phase == 2)));
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    // Cycles from now until tclk_o changes, sampled at falling edges
    task automatic half_len(output int n);
        logic v;
        v = tclk_o;
        n = 0;
        while (tclk_o == v && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic press();
        btn = 1'b1;
        @(negedge clk);
        btn = 1'b0;
    endtask

    initial begin
        int n;
        int k;
        repeat (3) @(negedge clk);
        chk(tclk_o == 1'b0 && run_o == 1'b0, "R1 reset outputs", int'({tclk_o, run_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tclk_o == 1'b1, "R1 first edge after reset", int'(tclk_o), 1);

        // R2: free running while stopped
        half_len(n);
        half_len(n);
        chk(n == 5, "R2 half period stopped", n, 5);
        half_len(n);
        chk(n == 5, "R2 half period repeat", n, 5);

        // R3: change period mid-half
        repeat (2) @(negedge clk);
        period_i = 16'd9;
        half_len(n);
        chk(n + 2 == 5, "R3 current half unchanged", n + 2, 5);
        half_len(n);
        chk(n == 9, "R3 next half uses new period", n, 9);

        // R4: clean start
        repeat (3) @(negedge clk);
        btn = 1'b1;
        k = 0;
        while (run_o == 1'b0 && k < 500) begin
            @(negedge clk);
            btn = 1'b0;
            k++;
            if (run_o == 1'b0)
                chk(tclk_o == 1'b0, "R4 low during window", int'(tclk_o), 0);
        end
        chk(k == PREP + 1, "R4 window length", k, PREP + 1);
        chk(tclk_o == 1'b1, "R4 edge with run", int'(tclk_o), 1);

        // R5: half periods after restart
        half_len(n);
        chk(n == 9, "R5 first half after restart", n, 9);
        half_len(n);
        chk(n == 9, "R5 second half after restart", n, 9);

        // R6: stop while running
        repeat (2) @(negedge clk);
        press();
        chk(run_o == 1'b0, "R6 run clears at once", int'(run_o), 0);
        half_len(n);
        chk(n == 9 - 3, "R6 phase undisturbed", n, 6);
        half_len(n);
        chk(n == 9, "R6 half period after stop", n, 9);

        // R7: extra press inside the window
        btn = 1'b1;
        k = 0;
        while (run_o == 1'b0 && k < 500) begin
            @(negedge clk);
            k++;
            btn = (k == 12);
        end
        btn = 1'b0;
        chk(k == PREP + 1, "R7 press in window ignored", k, PREP + 1);
        chk(run_o == 1'b1, "R7 running after window", int'(run_o), 1);

        // R10: tiny periods clamp to 2
        period_i = 16'd1;
        half_len(n);
        half_len(n);
        half_len(n);
        chk(n == 2, "R10 period 1 acts as 2", n, 2);
        period_i = 16'd0;
        half_len(n);
        half_len(n);
        half_len(n);
        chk(n == 2, "R10 period 0 acts as 2", n, 2);
        period_i = 16'd7;

        // R8: external mode follows the inputs one cycle late
        sync_ext = 1'b1;
        for (int i = 0; i < 24; i++) begin
            ext_clk = i[1] ^ i[0];
            ext_run = i[2];
            @(negedge clk);
            chk(tclk_o == ext_clk, "R8 ext clock follows", int'(tclk_o), int'(ext_clk));
            chk(run_o == ext_run, "R8 ext run follows", int'(run_o), int'(ext_run));
        end

        // R9: button ignored in external mode, then return
        ext_run = 1'b0;
        ext_clk = 1'b0;
        @(negedge clk);
        press();
        repeat (PREP + 5) @(negedge clk);
        chk(run_o == 1'b0, "R9 press ignored in ext mode", int'(run_o), 0);
        sync_ext = 1'b0;
        @(negedge clk);
        chk(tclk_o == 1'b0 && run_o == 1'b0, "R9 parked on return", int'({tclk_o, run_o}), 0);
        @(negedge clk);
        chk(tclk_o == 1'b1, "R9 first internal edge", int'(tclk_o), 1);
        half_len(n);
        chk(n == 7, "R9 half period after return", n, 7);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule